// File: doc/BRIEF.md
# Flash-Emulation Page Program and Erase Engine

This engine carries out program and erase requests for a flash array that is emulated in ordinary word-wide RAM. The host presents a request as a pending flag, two operation bits and a page index. The engine takes the request, walks the affected words through a single valid/ready memory port and raises a done flag when the last write has been accepted. It then holds that flag until the host acknowledges it.

Programming follows flash rules, so a program can only clear bits. For each word of the target page the engine reads the staging buffer, reads the current array word and writes back the bitwise AND of the two. Erase writes all-ones words. A sector erase first rounds the page index down to a sector boundary. A whole-array erase starts at page 0 and covers every page. Read data comes back on the memory port a fixed number of cycles after the read is accepted.

Top module: `flashemu_pgm_engine`

## Requirements
- R1: While `req_pending` is low and no operation is under way, `mem_valid` stays low and `done` stays low; both are low out of reset.
- R2: A request is taken from the idle state when `req_pending` is high. With `req_erase` = 0 it is a page program and `req_whole` has no effect. With `req_erase` = 1 and `req_whole` = 0 it is a sector erase. With `req_erase` = 1 and `req_whole` = 1 it is a whole-array erase.
- R3: A page program on page p handles words w = 0 .. PAGE_WORDS-1 in ascending order. For each word it makes three accesses: a read of `STAGE_BASE + 4w`, a read of `ARRAY_BASE + 4(p*PAGE_WORDS + w)`, and a write of the AND of the two read words to that same array address.
- R4: Every erase write carries an all-ones data word, and the words of the region are written in ascending address order.
- R5: A sector erase rounds the page index down to a multiple of SECTOR_PAGES and writes exactly SECTOR_PAGES*PAGE_WORDS words from that page onward.
- R6: A whole-array erase writes ARRAY_PAGES*PAGE_WORDS words starting at `ARRAY_BASE`. Writes never fall outside the array.
- R7: `done` rises in the cycle after the final write of the operation is accepted, and never earlier.
- R8: `done` stays high until `done_ack` is sampled high, after which the engine returns to idle. While an operation is running or `done` is high, changes on the request inputs cause no memory access.
- R9: While `mem_valid` is high and `mem_ready` is low, the engine keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged.
- R10: After a read is accepted in cycle c, the engine takes `mem_rdata` from cycle c + READ_LAT and from no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pending | input | 1 | A request is waiting |
| req_erase | input | 1 | 1 = erase, 0 = page program |
| req_whole | input | 1 | For erase: 1 = whole array, 0 = one sector |
| req_page | input | PIDX_W | Page index of the request |
| done_ack | input | 1 | Host acknowledges `done` |
| done | output | 1 | Operation finished, held until acknowledged |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DATA_W | Read data, valid READ_LAT cycles after acceptance |

## Verification
The bench builds the engine with 16-byte pages (four words), 4-page sectors, a 16-page array and a read latency of 2. With these sizes a whole-array erase is only 64 writes, so every operation runs to completion. A sector erase from an unaligned page visibly moves its start back to the sector boundary, and the last page of the array can be programmed. In the same small setting, the three ready patterns (always ready, pseudo-random, long low stretches) hit stalls on reads and writes at many points of each operation. Junk on `mem_rdata` outside the due cycle makes any mistimed read capture show up as wrong write data.

// File: rtl/flashemu_pkg.sv
package flashemu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_STG = 3'd1,
    ST_WT_STG = 3'd2,
    ST_RD_TGT = 3'd3,
    ST_WT_TGT = 3'd4,
    ST_WRITE  = 3'd5,
    ST_DONE   = 3'd6
  } fe_state_e;

  typedef enum logic [1:0] {
    FE_OP_PROG         = 2'd0,
    FE_OP_ERASE_SECTOR = 2'd1,
    FE_OP_ERASE_ARRAY  = 2'd2
  } fe_op_e;

endpackage

// File: rtl/fe_req_decode.sv
module fe_req_decode
  import flashemu_pkg::*;
#(
  parameter int unsigned PIDX_W       = 10,
  parameter int unsigned PAGE_WORDS   = 32,
  parameter int unsigned SECTOR_PAGES = 128,
  parameter int unsigned ARRAY_PAGES  = 1024,
  parameter int unsigned WOFF_W       = 15,
  parameter int unsigned CNT_W        = 16
) (
  input  logic              erase_i,
  input  logic              whole_i,
  input  logic [PIDX_W-1:0] page_i,
  output fe_op_e            op_o,
  output logic [WOFF_W-1:0] start_word_o,
  output logic [CNT_W-1:0]  word_total_o
);

  localparam int unsigned PW_LOG = $clog2(PAGE_WORDS);
  localparam logic [PIDX_W-1:0] SEC_MASK = PIDX_W'(SECTOR_PAGES - 1);

  logic [PIDX_W-1:0] page_eff;

  // R2 / R5 / R6: operation select, sector alignment, region length
  always_comb begin
    if (!erase_i) begin
      op_o         = FE_OP_PROG;
      page_eff     = page_i;
      word_total_o = CNT_W'(PAGE_WORDS);
    end else if (!whole_i) begin
      op_o         = FE_OP_ERASE_SECTOR;
      page_eff     = page_i & ~SEC_MASK;
      word_total_o = CNT_W'(SECTOR_PAGES * PAGE_WORDS);
    end else begin
      op_o         = FE_OP_ERASE_ARRAY;
      page_eff     = '0;
      word_total_o = CNT_W'(ARRAY_PAGES * PAGE_WORDS);
    end
  end

  assign start_word_o = WOFF_W'(page_eff) << PW_LOG;

endmodule

// File: rtl/fe_word_walker.sv
module fe_word_walker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr_i | adv_i;
    idx_d  = clr_i ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == total_i - 1'b1);

  // R5 / R6: the word offset never leaves the selected region
  a_r5_idx_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (idx_q < total_i));

endmodule

// File: rtl/fe_lat_timer.sv
module fe_lat_timer #(
  parameter int unsigned READ_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic fire_o
);

  localparam int unsigned LW = $clog2(READ_LAT + 1);

  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (launch_i)           cnt_d = LW'(READ_LAT);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: data is due in the cycle where one count remains
  assign fire_o = (cnt_q == LW'(1));

  // R10: a new read is never launched while one is still in flight
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (cnt_q == '0));

endmodule

// File: rtl/flashemu_pgm_engine.sv
module flashemu_pgm_engine
  import flashemu_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PAGE_BYTES   = 128,
  parameter int unsigned SECTOR_PAGES = 128,
  parameter int unsigned ARRAY_PAGES  = 1024,
  parameter int unsigned PIDX_W       = 10,
  parameter int unsigned READ_LAT     = 2,
  parameter logic [ADDR_W-1:0] ARRAY_BASE = 'h0010_0000,
  parameter logic [ADDR_W-1:0] STAGE_BASE = 'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_pending,
  input  logic              req_erase,
  input  logic              req_whole,
  input  logic [PIDX_W-1:0] req_page,
  input  logic              done_ack,
  output logic              done,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned BPW         = DATA_W / 8;
  localparam int unsigned BW_LOG      = $clog2(BPW);
  localparam int unsigned PAGE_WORDS  = PAGE_BYTES / BPW;
  localparam int unsigned PW_LOG      = $clog2(PAGE_WORDS);
  localparam int unsigned WOFF_W      = PIDX_W + PW_LOG;
  localparam int unsigned ARRAY_WORDS = ARRAY_PAGES * PAGE_WORDS;
  localparam int unsigned CNT_W       = $clog2(ARRAY_WORDS + 1);
  localparam int unsigned AW1         = ADDR_W + 1;
  localparam logic [ADDR_W:0] ARRAY_END = {1'b0, ARRAY_BASE} + AW1'(ARRAY_WORDS * BPW);

  fe_state_e         state_q, state_d;
  logic              lat_erase_q, lat_whole_q;
  logic [PIDX_W-1:0] lat_page_q;
  logic [DATA_W-1:0] stg_q, tgt_q;
  logic              take, rd_launch, rd_fire, wr_accept, last, busy;
  logic              cap_stg, cap_tgt;
  fe_op_e            op;
  logic [WOFF_W-1:0] start_word;
  logic [CNT_W-1:0]  word_total, word_idx;
  logic [ADDR_W-1:0] stg_addr, arr_addr;

  // ---------------- request latch ----------------
  assign take = (state_q == ST_IDLE) && req_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_erase_q <= 1'b0;
      lat_whole_q <= 1'b0;
      lat_page_q  <= '0;
    end else if (take) begin
      lat_erase_q <= req_erase;
      lat_whole_q <= req_whole;
      lat_page_q  <= req_page;
    end
  end

  fe_req_decode #(
    .PIDX_W       (PIDX_W),
    .PAGE_WORDS   (PAGE_WORDS),
    .SECTOR_PAGES (SECTOR_PAGES),
    .ARRAY_PAGES  (ARRAY_PAGES),
    .WOFF_W       (WOFF_W),
    .CNT_W        (CNT_W)
  ) u_decode (
    .erase_i      (lat_erase_q),
    .whole_i      (lat_whole_q),
    .page_i       (lat_page_q),
    .op_o         (op),
    .start_word_o (start_word),
    .word_total_o (word_total)
  );

  // ---------------- word walker and read timer ----------------
  assign wr_accept = (state_q == ST_WRITE) && mem_ready;
  assign rd_launch = ((state_q == ST_RD_STG) || (state_q == ST_RD_TGT)) && mem_ready;
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);

  fe_word_walker #(
    .CNT_W    (CNT_W)
  ) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (take),
    .adv_i    (wr_accept),
    .active_i (busy),
    .total_i  (word_total),
    .idx_o    (word_idx),
    .last_o   (last)
  );

  fe_lat_timer #(
    .READ_LAT (READ_LAT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (rd_launch),
    .fire_o   (rd_fire)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_pending) state_d = req_erase ? ST_WRITE : ST_RD_STG;
      ST_RD_STG: if (mem_ready)   state_d = ST_WT_STG;
      ST_WT_STG: if (rd_fire)     state_d = ST_RD_TGT;
      ST_RD_TGT: if (mem_ready)   state_d = ST_WT_TGT;
      ST_WT_TGT: if (rd_fire)     state_d = ST_WRITE;
      ST_WRITE: begin
        if (mem_ready) begin
          if (last)                   state_d = ST_DONE;
          else if (op == FE_OP_PROG)  state_d = ST_RD_STG;
          else                        state_d = ST_WRITE;
        end
      end
      ST_DONE:   if (done_ack)    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // ---------------- read data capture ----------------
  assign cap_stg = (state_q == ST_WT_STG) && rd_fire;
  assign cap_tgt = (state_q == ST_WT_TGT) && rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stg_q <= '0;
    else if (cap_stg) stg_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgt_q <= '0;
    else if (cap_tgt) tgt_q <= mem_rdata;
  end

  // ---------------- memory port ----------------
  assign stg_addr  = STAGE_BASE + (ADDR_W'(word_idx) << BW_LOG);
  assign arr_addr  = ARRAY_BASE + ((ADDR_W'(start_word) + ADDR_W'(word_idx)) << BW_LOG);

  assign mem_valid = (state_q == ST_RD_STG) || (state_q == ST_RD_TGT) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_RD_STG) ? stg_addr : arr_addr;
  assign mem_wdata = (op == FE_OP_PROG) ? (stg_q & tgt_q) : '1;
  assign done      = (state_q == ST_DONE);

  // ---------------- assertions ----------------
  // R9: a stalled access holds still
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

  // R7: done only follows an accepted write
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_valid && mem_we && mem_ready));

  // R8: done only drops after an acknowledge
  a_r8_done_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(done_ack));

  // R6: writes stay inside the array
  a_r6_write_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (({1'b0, mem_addr} >= {1'b0, ARRAY_BASE}) &&
                               ({1'b0, mem_addr} < ARRAY_END)));

  // R4: erase data is all ones
  a_r4_erase_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && lat_erase_q) |-> (&mem_wdata));

endmodule

// File: tb/test_flashemu_pgm_engine.sv
module test_flashemu_pgm_engine;

  localparam int unsigned ADDR_W       = 32;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned PAGE_BYTES   = 16;
  localparam int unsigned SECTOR_PAGES = 4;
  localparam int unsigned ARRAY_PAGES  = 16;
  localparam int unsigned PIDX_W       = 10;
  localparam int unsigned READ_LAT     = 2;
  localparam logic [31:0] ARRAY_BASE   = 32'h0000_0400;
  localparam logic [31:0] STAGE_BASE   = 32'h0000_0000;
  localparam int unsigned PW           = PAGE_BYTES / 4;
  localparam int unsigned MEM_WORDS    = 512;

  logic              clk;
  logic              rst_n;
  logic              req_pending, req_erase, req_whole, done_ack;
  logic [PIDX_W-1:0] req_page;
  logic              done, mem_valid, mem_we, mem_ready;
  logic [31:0]       mem_addr, mem_wdata, mem_rdata;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  flashemu_pgm_engine #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .SECTOR_PAGES (SECTOR_PAGES),
    .ARRAY_PAGES  (ARRAY_PAGES),
    .PIDX_W       (PIDX_W),
    .READ_LAT     (READ_LAT),
    .ARRAY_BASE   (ARRAY_BASE),
    .STAGE_BASE   (STAGE_BASE)
  ) i_flashemu_pgm_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pending (req_pending),
    .req_erase   (req_erase),
    .req_whole   (req_whole),
    .req_page    (req_page),
    .done_ack    (done_ack),
    .done        (done),
    .mem_valid   (mem_valid),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    int          rq;
  } xact_t;

  logic [31:0] mem    [MEM_WORDS];
  logic [31:0] shadow [MEM_WORDS];
  xact_t       expq[$];
  int unsigned rd_due[$];
  logic [31:0] rd_dat[$];

  int          n_cmp, n_bad;
  int unsigned cyc;
  bit          exp_done, wd_hit;
  int          ready_mode;
  logic [15:0] lfsr;
  bit          prev_stall, prev_we;
  logic [31:0] prev_addr;

  function automatic void chk(bit ok, int rq, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endfunction

  // Expected access stream for one request (R2..R6)
  function automatic void build(bit er, bit wh, int page);
    int start, words;
    xact_t x;
    if (!er) begin
      start = page * PW;
      for (int w = 0; w < PW; w++) begin
        int si, ti;
        si = int'(STAGE_BASE >> 2) + w;
        ti = int'(ARRAY_BASE >> 2) + start + w;
        x.we = 0; x.addr = STAGE_BASE + 32'(4*w); x.data = '0; x.rq = 3; expq.push_back(x);
        x.we = 0; x.addr = ARRAY_BASE + 32'(4*(start+w)); x.rq = 3; expq.push_back(x);
        x.we = 1; x.data = mem[si] & shadow[ti]; x.rq = 3; expq.push_back(x);
        shadow[ti] = x.data;
      end
    end else begin
      if (!wh) begin
        start = (page / SECTOR_PAGES) * SECTOR_PAGES * PW;  // R5 alignment
        words = SECTOR_PAGES * PW;
      end else begin
        start = 0;                                          // R6
        words = ARRAY_PAGES * PW;
      end
      for (int w = 0; w < words; w++) begin
        x.we = 1; x.addr = ARRAY_BASE + 32'(4*(start+w)); x.data = 32'hFFFF_FFFF;
        x.rq = wh ? 6 : 5;
        expq.push_back(x);
        shadow[int'(ARRAY_BASE >> 2) + start + w] = 32'hFFFF_FFFF;
      end
    end
  endfunction

  // Reference model: one evaluation per cycle, at the falling edge
  function automatic void eval();
    bit next_done;
    xact_t h;
    int idx;
    next_done = exp_done;
    case (ready_mode)
      0:       mem_ready = 1'b1;
      1:       mem_ready = lfsr[0] | lfsr[3];
      default: mem_ready = ((cyc % 10) >= 7);
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rdata = 32'hBAD0_0000 ^ cyc;                       // junk off the due cycle (R10)
    if (rd_due.size() != 0 && rd_due[0] == cyc) begin
      mem_rdata = rd_dat[0];
      void'(rd_due.pop_front());
      void'(rd_dat.pop_front());
    end

    chk(done === exp_done, 7, 32'(done), 32'(exp_done), "done flag");   // R7 / R8
    if (expq.size() == 0)
      chk(mem_valid === 1'b0, exp_done ? 8 : 1, 32'(mem_valid), 0, "idle access");
    if (prev_stall)
      chk(mem_valid === 1'b1 && mem_addr === prev_addr && mem_we === prev_we, 9,
          mem_addr, prev_addr, "stalled access moved");

    if (mem_valid === 1'b1 && mem_ready) begin
      if (expq.size() == 0) begin
        chk(0, 8, mem_addr, 0, "unexpected access");
      end else begin
        h = expq.pop_front();
        chk(mem_we === h.we, h.rq, 32'(mem_we), 32'(h.we), "access direction");
        chk(mem_addr === h.addr, h.rq, mem_addr, h.addr, "access address");
        if (h.we)
          chk(mem_wdata === h.data, (h.rq == 3) ? 10 : 4, mem_wdata, h.data, "write data");
        if (expq.size() == 0) next_done = 1;
      end
      idx = int'(mem_addr >> 2);
      if (idx < int'(MEM_WORDS)) begin
        if (mem_we) mem[idx] = mem_wdata;
        else begin
          rd_due.push_back(cyc + READ_LAT);
          rd_dat.push_back(mem[idx]);
        end
      end
    end
    prev_stall = (mem_valid === 1'b1) && !mem_ready;
    prev_addr  = mem_addr;
    prev_we    = mem_we;

    if (exp_done && done_ack) next_done = 0;
    if (!exp_done && !next_done && expq.size() == 0 && req_pending)
      build(req_erase, req_whole, int'(req_page));
    exp_done = next_done;
    cyc++;
  endfunction

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step();
    eval();
    @(negedge clk);
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      chk(0, 7, 32'(cyc), 0, "watchdog expired");
      summary_and_end();
    end
  endtask

  task automatic set_stage(int seed);
    for (int w = 0; w < PW; w++) begin
      mem[int'(STAGE_BASE >> 2) + w]    = (32'(seed) * 32'h0101_0107) ^ (32'h0F0F_F0F0 >> w);
      shadow[int'(STAGE_BASE >> 2) + w] = mem[int'(STAGE_BASE >> 2) + w];
    end
  endtask

  task automatic run_op(bit er, bit wh, int page, int rmode, int hold, bit scramble);
    int guard;
    ready_mode  = rmode;
    req_erase   = er;
    req_whole   = wh;
    req_page    = PIDX_W'(page);
    req_pending = 1'b1;
    step();
    guard = 0;
    while (!exp_done && guard < 20000) begin
      if (scramble) begin                       // R8: ignored while busy
        req_page  = lfsr[PIDX_W-1:0];
        req_erase = ~req_erase;
        req_whole = lfsr[1];
      end
      step();
      guard++;
    end
    repeat (hold) step();                       // R8: pending still high while done
    req_pending = 1'b0;
    done_ack    = 1'b1;
    step();
    done_ack    = 1'b0;
    step();
    step();
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; exp_done = 0; wd_hit = 0;
    ready_mode = 0; lfsr = 16'hACE1; prev_stall = 0; prev_we = 0; prev_addr = '0;
    rst_n = 1'b0; req_pending = 1'b0; req_erase = 1'b0; req_whole = 1'b0;
    req_page = '0; done_ack = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    for (int i = 0; i < int'(MEM_WORDS); i++) begin
      mem[i]    = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done === 1'b0, 1, 32'(done), 0, "done in reset");
    chk(mem_valid === 1'b0, 1, 32'(mem_valid), 0, "valid in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fields set but nothing pending
    req_erase = 1'b1; req_whole = 1'b1; req_page = 10'd3;
    repeat (10) step();

    set_stage(1); run_op(0, 0, 5, 0, 0, 0);    // R3 program, no stalls
    set_stage(2); run_op(0, 1, 5, 1, 3, 1);    // R2 whole bit ignored, R9 stalls, R3 only clears bits
    run_op(1, 0, 6, 2, 5, 0);                  // R5 unaligned sector erase, R4
    set_stage(3); run_op(0, 0, 6, 1, 0, 0);    // R3 into erased page, R10
    run_op(1, 0, 9, 0, 0, 1);                  // R5 second sector
    run_op(1, 1, 7, 2, 2, 1);                  // R6 whole-array erase
    set_stage(4); run_op(0, 0, 15, 1, 0, 0);   // R3 last page of array
    set_stage(5); run_op(0, 0, 0, 2, 0, 0);    // R3 first page, long stalls

    // R3 / R4: final contents everywhere match the expected image
    for (int i = 0; i < int'(MEM_WORDS); i++)
      chk(mem[i] === shadow[i], 4, mem[i], shadow[i], "final memory image");

    summary_and_end();
  end

endmodule